// File: doc/BRIEF.md
# Token-Ring Running Median Filter

This block is a streaming median filter over a sliding window of `N` samples, with `N` odd (default 5). One sample may be offered per clock under `in_valid`. The filter keeps the window in `N` cells. Each cell holds a sample, the rank of that sample within the window, and a token bit. A single token marks the cell with the oldest sample. An accepted sample overwrites that cell, and the token then moves one cell along the ring.

Samples never move between cells. Only the ranks change. The token cell's rank is driven onto a shared rank bus. Every other cell compares its own rank with that bus value, and compares its sample with the incoming one, to adjust its rank by at most one. A second pipeline stage picks the sample whose rank is the middle one and registers it as the median.

The window starts filled with zeros. Medians therefore count those zeros until `N` real samples have arrived, and a sticky flag marks the point from which the output is meaningful.

Top module: `run_median_filter`

## Requirements
- R1: While `rst_n` is low and after its release, `y` is 0, `out_strobe` is 0 and `median_valid` is 0 until samples arrive.
- R2: Each accepted sample replaces the sample accepted `N` acceptances earlier (an initial zero while fewer than `N` have arrived). Exactly one cell holds the token, and the token advances one cell per accepted sample, wrapping around the ring.
- R3: Cycles with `in_valid` low change neither the window nor `y`, and produce no `out_strobe`.
- R4: For a sample accepted at clock edge k, `y` carries the resulting median from edge k+1 on.
- R5: The median is the ((N+1)/2)-th smallest of the `N` window samples, initial zeros included.
- R6: `median_valid` goes high together with the output for the ((N+1)/2)-th accepted sample and stays high until reset.
- R7: `out_strobe` is high for exactly the one cycle after each median update, and only once `median_valid` holds.
- R8: Equal sample values are handled correctly: ties give distinct ranks, with the newer sample ranked above older equal samples, and the median value is still exact.
- R9: Samples may be accepted on every consecutive cycle with no bubble.
- R10: The extreme values 0 and 2^W-1 are filtered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Qualifies `in_sample` this cycle |
| in_sample | input | W | Unsigned incoming sample |
| y | output | W | Registered window median |
| out_strobe | output | 1 | One-cycle pulse on each valid median update |
| median_valid | output | 1 | Sticky: enough samples have entered the window |

## Verification
The in-RTL assertions check these properties on every cycle:
- a single token that steps exactly one cell per accepted sample;
- ranks that never exceed `N`;
- exactly one cell at the middle rank whenever a median is taken;
- `y` frozen without a pending update;
- a sticky `median_valid` that covers every strobe.

Only the bench's scenarios can show that the median value is right. They cover:
- the eviction order;
- tie handling;
- extreme values;
- gapped and back-to-back streams.

For these, the bench compares every cycle against a sorted model of the last `N` samples.

// File: rtl/mf_pkg.sv
package mf_pkg;

  // Width needed to hold a rank in 0..n
  function automatic int rank_width(input int n);
    return $clog2(n + 1);
  endfunction

  // Rank of the median in a window of n (odd) samples
  function automatic int mid_rank(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/mf_cell.sv
module mf_cell #(
  parameter int N       = 5,
  parameter int W       = 8,
  parameter int RW      = 3,
  parameter bit TOK_RST = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [W-1:0]  x,
  input  logic [RW-1:0] bus_rank,
  input  logic [RW-1:0] le_others,
  input  logic          tok_in,
  output logic [W-1:0]  r,
  output logic [RW-1:0] p,
  output logic          t,
  output logic          le
);

  logic [W-1:0]  r_nxt;
  logic [RW-1:0] p_nxt;
  logic          t_nxt;
  logic          above_leaver;
  logic          below_new;

  // Stored sample is at most the incoming one (feeds token cell's rank)
  assign le = (r <= x);

  assign above_leaver = (p > bus_rank);
  assign below_new    = (x < r);

  always_comb begin
    r_nxt = r;
    p_nxt = p;
    t_nxt = tok_in;
    if (t) begin
      // Token cell takes the new sample; newest ranks above equal older ones
      r_nxt = x;
      p_nxt = le_others + RW'(1);
    end else begin
      p_nxt = p - RW'(above_leaver) + RW'(below_new);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= '0;
      p <= '0;
      t <= TOK_RST;
    end else if (accept) begin
      r <= r_nxt;
      p <= p_nxt;
      t <= t_nxt;
    end
  end

  // R5: a rank never leaves the range 0..N
  p_rank_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    p <= RW'(N));

endmodule

// File: rtl/mf_rank_bus.sv
module mf_rank_bus #(
  parameter int N  = 5,
  parameter int RW = 3
) (
  input  logic [RW-1:0] p [N],
  input  logic [N-1:0]  t,
  input  logic [N-1:0]  le,
  output logic [RW-1:0] bus_rank,
  output logic [RW-1:0] le_cnt
);

  // AND/OR one-hot mux of the token cell's rank, and count of
  // non-token cells whose sample is <= the incoming one
  always_comb begin
    bus_rank = '0;
    le_cnt   = '0;
    for (int i = 0; i < N; i++) begin
      bus_rank = bus_rank | (p[i] & {RW{t[i]}});
      le_cnt   = le_cnt + RW'(le[i] & ~t[i]);
    end
  end

endmodule

// File: rtl/mf_median_sel.sv
module mf_median_sel #(
  parameter int N   = 5,
  parameter int W   = 8,
  parameter int RW  = 3,
  parameter int MID = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          enough,
  input  logic [W-1:0]  r [N],
  input  logic [RW-1:0] p [N],
  output logic [W-1:0]  y,
  output logic          out_strobe,
  output logic          median_valid
);

  logic [N-1:0] hit;
  logic [W-1:0] med;
  logic [W-1:0] y_nxt;
  logic         strobe_nxt;
  logic         mv_nxt;

  always_comb begin
    med = '0;
    for (int i = 0; i < N; i++) begin
      hit[i] = (p[i] == RW'(MID));
      med    = med | (r[i] & {W{hit[i]}});
    end
  end

  always_comb begin
    y_nxt      = y;
    strobe_nxt = 1'b0;
    mv_nxt     = median_valid;
    if (upd) begin
      y_nxt      = med;
      strobe_nxt = enough;
      mv_nxt     = median_valid | enough;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y            <= '0;
      out_strobe   <= 1'b0;
      median_valid <= 1'b0;
    end else begin
      y            <= y_nxt;
      out_strobe   <= strobe_nxt;
      median_valid <= mv_nxt;
    end
  end

  // R5: once enough samples exist, exactly one cell sits at the middle rank
  p_single_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && enough) |-> ($countones(hit) == 1));

  // R3: without a pending update the output holds
  p_hold_y_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(y));

  // R7: a strobe only appears with median_valid high
  p_strobe_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> median_valid);

  // R6: median_valid is sticky
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    median_valid |=> median_valid);

endmodule

// File: rtl/run_median_filter.sv
module run_median_filter #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_sample,
  output logic [W-1:0] y,
  output logic         out_strobe,
  output logic         median_valid
);
  import mf_pkg::*;

  localparam int RW  = rank_width(N);
  localparam int MID = mid_rank(N);
  localparam int FW  = $clog2(MID + 1);

  logic [W-1:0]  cell_r [N];
  logic [RW-1:0] cell_p [N];
  logic [N-1:0]  tok;
  logic [N-1:0]  le;
  logic [N-1:0]  tok_rot;
  logic [RW-1:0] bus_rank;
  logic [RW-1:0] le_cnt;

  logic          s1_valid;
  logic          s1_valid_nxt;
  logic [FW-1:0] fill;
  logic [FW-1:0] fill_nxt;
  logic          enough;

  // Stage 1: per-cell rank update, insertion, token pass
  for (genvar i = 0; i < N; i++) begin : g_cell
    mf_cell #(
      .N(N), .W(W), .RW(RW),
      .TOK_RST(i == N - 1)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (in_valid),
      .x         (in_sample),
      .bus_rank  (bus_rank),
      .le_others (le_cnt),
      .tok_in    (tok[(i + N - 1) % N]),
      .r         (cell_r[i]),
      .p         (cell_p[i]),
      .t         (tok[i]),
      .le        (le[i])
    );
  end

  mf_rank_bus #(.N(N), .RW(RW)) u_bus (
    .p        (cell_p),
    .t        (tok),
    .le       (le),
    .bus_rank (bus_rank),
    .le_cnt   (le_cnt)
  );

  // Fill counter saturating at the median rank; stage-2 valid
  always_comb begin
    s1_valid_nxt = in_valid;
    fill_nxt     = fill;
    if (in_valid && (fill < FW'(MID))) begin
      fill_nxt = fill + FW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      fill     <= '0;
    end else begin
      s1_valid <= s1_valid_nxt;
      fill     <= fill_nxt;
    end
  end

  assign enough = (fill >= FW'(MID));

  // Stage 2: median selection
  mf_median_sel #(.N(N), .W(W), .RW(RW), .MID(MID)) u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd          (s1_valid),
    .enough       (enough),
    .r            (cell_r),
    .p            (cell_p),
    .y            (y),
    .out_strobe   (out_strobe),
    .median_valid (median_valid)
  );

  assign tok_rot = {tok[N-2:0], tok[N-1]};

  // R2: exactly one token at all times
  p_token_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok) == 1);

  // R2: token steps one cell per accepted sample
  p_token_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (tok == $past(tok_rot)));

  // R3: token holds on idle cycles
  p_token_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(tok));

endmodule

// File: tb/run_median_filter_test.sv
`timescale 1ns/1ps
module run_median_filter_test;
  localparam int N   = 5;
  localparam int W   = 8;
  localparam int MID = (N + 1) / 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_sample;
  logic [W-1:0] y;
  logic         out_strobe;
  logic         median_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] win [N];
  int           ptr;
  int           cnt;
  bit           pend;
  logic [W-1:0] exp_y;
  bit           exp_st;
  bit           exp_mv;
  logic [15:0]  lfsr;

  always #2.5 clk = ~clk;

  run_median_filter #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .y(y), .out_strobe(out_strobe), .median_valid(median_valid)
  );

  function automatic logic [W-1:0] model_median();
    logic [W-1:0] s [N];
    logic [W-1:0] tmp;
    for (int i = 0; i < N; i++) s[i] = win[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (s[j] > s[j+1]) begin tmp = s[j]; s[j] = s[j+1]; s[j+1] = tmp; end
    return s[MID-1];
  endfunction

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input bit v, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    in_valid  = v;
    in_sample = d;
    @(posedge clk);
    #1;
    if (pend) begin
      exp_y  = model_median();
      exp_st = (cnt >= MID);
      exp_mv = exp_mv | exp_st;
    end else begin
      exp_st = 0;
    end
    if (v) begin
      win[ptr] = d;
      ptr = (ptr + 1) % N;
      if (cnt < MID) cnt++;
      pend = 1;
    end else begin
      pend = 0;
    end
    check(tag, y, exp_y);
    check("R7 strobe", out_strobe, exp_st);
    check("R6 median_valid", median_valid, exp_mv);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sample = '0;
    for (int i = 0; i < N; i++) win[i] = '0;
    ptr = 0; cnt = 0; pend = 0; exp_y = '0; exp_st = 0; exp_mv = 0;
    lfsr = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 y in reset", y, 0);
    check("R1 strobe in reset", out_strobe, 0);
    check("R1 valid in reset", median_valid, 0);
    @(negedge clk); rst_n = 1;
    step(0, 8'd0, "R1 idle after reset");

    // R4/R6: first samples into a zero window (12 ranks highest)
    step(1, 8'd12, "R4 first sample");
    step(1, 8'd7,  "R4 second");
    step(1, 8'd3,  "R4 third");
    step(1, 8'd66, "R4 fourth");
    step(1, 8'd52, "R4 fifth");
    step(0, 8'd99, "R4 drain");
    // R3: idle with garbage on the data input
    for (int i = 0; i < 6; i++) step(0, 8'(i * 37), "R3 idle");
    // R2: eviction order, strictly rising then falling
    for (int i = 0; i < 12; i++) step(1, 8'(i * 20), "R2 rising");
    for (int i = 0; i < 12; i++) step(1, 8'(240 - i * 20), "R2 falling");
    // R9/R5: back-to-back full-range stream
    for (int i = 0; i < 1500; i++) begin
      lfsr = lfsr_next(lfsr);
      step(1, lfsr[7:0], "R9 back-to-back");
    end
    // R8: heavy ties with random gaps
    for (int i = 0; i < 1500; i++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[5] | lfsr[9], 8'(lfsr[1:0]), "R8 ties");
    end
    // R10: extremes
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr_next(lfsr);
      step(1, lfsr[3] ? 8'hFF : 8'h00, "R10 extremes");
    end
    // R5: mixed stream with gaps
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[2], lfsr[15:8], "R5 gapped");
    end
    step(0, 8'd0, "R3 final idle");
    step(0, 8'd0, "R3 final idle");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule